// File: doc/BRIEF.md
# Interconnect Crosstalk Self-Test Pattern Generator

This block drives an n-net interconnect with a new stimulus vector on every clock, at full speed, and folds what comes back from the far end into a signature. Stimulus comes from a maximal-length shift register that is twice as long as the net count. Only its even stages drive the nets. With that spacing, every two-vector transition that can excite a crosstalk fault appears on the nets as two consecutive clock cycles. A further n-stage multiple-input signature register (MISR) absorbs the returning net values on the same clocks.

Software picks a seed and a cycle count g. A start pulse loads the seed into the whole 3n-stage register and latches g. The block then advances exactly g times, raises done and freezes. The frozen 3n-bit state is the signature, which is compared against a value computed offline.

The stimulus and response ports carry no valid/ready handshake. A test-per-clock session cannot accept back-pressure: a stalled cycle would insert a repeated vector and break the two-pattern timing. Start and done are plain control pins.

Top module: `xtalk_bist`

## Requirements
- R1: After reset, done is 0, signature is all zeros and stim is all zeros, and no stepping takes place until a start.
- R2: A clock edge with start high loads seed[2N-1:0] into the generator and seed[3N-1:2N] into the MISR, latches cycles as g and clears the step count. This applies even while a session is running, which it then abandons.
- R3: stim[i] always equals generator stage 2*i, for i from 0 to N-1.
- R4: Each generator step shifts the stages toward the higher index. The new stage 0 is the XOR of the tapped stages. Tap masks per 2N, as bit positions: 16:{15,14,12,3}, 24:{23,22,21,16}, 32:{31,21,1,0}, 40:{39,37,20,18}, 48:{47,46,20,19}, 56:{55,54,35,34}, 64:{63,62,60,59}.
- R5: From any nonzero generator seed, the generator state first returns to the seed after 2^(2N)-1 steps. An all-zero generator state stays all zero.
- R6: Each MISR step computes next = {m[N-2:0], ^(m & T)} ^ resp. The masks T per N, as bit positions, are: 8:{7,5,4,3}, 12:{11,5,3,0}, 16 and 24 as for the generator, 20:{19,16}, 28:{27,24}, 32:{31,21,1,0}.
- R7: A session performs exactly g steps, one per clock after the start edge. done rises on the g-th of those edges. With g = 0, done rises on the start edge itself and no step occurs.
- R8: While done is 1 and start is low, the generator, the MISR and done all hold, and resp has no effect.
- R9: signature is {MISR, generator}, so that the generator occupies bits [2N-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the seed and begins a session |
| seed | input | 3*N | Initial state, with the MISR in the upper N bits |
| cycles | input | CNT_W | Step count g, sampled at start |
| stim | output | N | Stimulus to the nets under test |
| resp | input | N | Values returning from the nets |
| done | output | 1 | Session complete, state frozen |
| signature | output | 3*N | Frozen register state |

## Verification
The assertions take for granted that resp is synchronous to clk and settled before each rising edge, and that cycles is meaningful only on the start edge. They also assume a reset precedes any start. The bench changes every input on the falling edge and derives resp combinationally from stim, or holds it constant, so it is always stable at the sampling edge. It pulses start for exactly one edge except in the restart scenario, which asserts start deliberately in the middle of a session.

// File: rtl/xbist_pkg.sv
package xbist_pkg;
  // Primitive feedback masks indexed by register length (bit k-1 for tap k)
  function automatic logic [63:0] tap_mask(input int len);
    case (len)
      8:  tap_mask = 64'h0000_0000_0000_00B8;
      12: tap_mask = 64'h0000_0000_0000_0829;
      16: tap_mask = 64'h0000_0000_0000_D008;
      20: tap_mask = 64'h0000_0000_0009_0000;
      24: tap_mask = 64'h0000_0000_00E1_0000;
      28: tap_mask = 64'h0000_0000_0900_0000;
      32: tap_mask = 64'h0000_0000_8020_0003;
      40: tap_mask = 64'h0000_00A0_0014_0000;
      48: tap_mask = 64'h0000_C000_0018_0000;
      56: tap_mask = 64'h00C0_000C_0000_0000;
      64: tap_mask = 64'hD800_0000_0000_0000;
      default: tap_mask = 64'h0;
    endcase
  endfunction
endpackage

// File: rtl/xbist_gen.sv
module xbist_gen #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*N-1:0] seed,
  output logic [2*N-1:0] state,
  output logic [N-1:0]   stim
);
  localparam int W = 2 * N;
  localparam logic [63:0] FULL = xbist_pkg::tap_mask(W);
  localparam logic [W-1:0] MASK = FULL[W-1:0];

  logic fb;
  assign fb = ^(state & MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= seed;
    else if (step) state <= {state[W-2:0], fb};
  end

  // only alternate stages reach the nets
  for (genvar i = 0; i < N; i++) begin : g_tap
    assign stim[i] = state[2*i];
  end

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == $past(seed));

  // R5
  zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == '0 && !load) |=> state == '0);

  // R8
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state));
endmodule

// File: rtl/xbist_misr.sv
module xbist_misr #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] seed,
  input  logic [N-1:0] resp,
  output logic [N-1:0] state
);
  localparam logic [63:0] FULL = xbist_pkg::tap_mask(N);
  localparam logic [N-1:0] MASK = FULL[N-1:0];

  logic [N-1:0] nxt;
  assign nxt = {state[N-2:0], ^(state & MASK)} ^ resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= seed;
    else if (step) state <= nxt;
  end

  // R8
  misr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state));
endmodule

// File: rtl/xbist_ctrl.sv
module xbist_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             step,
  output logic             done
);
  logic [CNT_W-1:0] cnt, g_q;
  logic             running;

  assign step = running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; g_q <= '0; running <= 1'b0; done <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      g_q     <= cycles;
      running <= (cycles != '0);
      done    <= (cycles == '0);
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (cnt + 1'b1 == g_q) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt < g_q);

  // R7
  run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && done));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/xtalk_bist.sv
module xtalk_bist #(
  parameter int N     = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3*N-1:0]   seed,
  input  logic [CNT_W-1:0] cycles,
  output logic [N-1:0]     stim,
  input  logic [N-1:0]     resp,
  output logic             done,
  output logic [3*N-1:0]   signature
);
  localparam int GW = 2 * N;

  logic          step;
  logic [GW-1:0] gen_q;
  logic [N-1:0]  misr_q;

  xbist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cycles(cycles),
    .step(step), .done(done)
  );

  xbist_gen #(.N(N)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step),
    .seed(seed[GW-1:0]), .state(gen_q), .stim(stim)
  );

  xbist_misr #(.N(N)) u_misr (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step),
    .seed(seed[3*N-1:GW]), .resp(resp), .state(misr_q)
  );

  assign signature = {misr_q, gen_q};

  // R8
  sig_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(signature));

  // R7
  zero_g_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cycles == '0) |=> done);
endmodule

// File: tb/sim_xtalk_bist.sv
module sim_xtalk_bist;
  localparam int N = 8;
  localparam logic [15:0] GT = 16'hD008;  // R4 taps for 2N=16
  localparam logic [7:0]  MT = 8'hB8;     // R6 taps for N=8

  logic clk = 0, rst_n = 0, start = 0;
  logic [23:0] seed = '0;
  logic [15:0] cycles = '0;
  logic [7:0]  stim, resp, cval = '0;
  logic        done;
  logic [23:0] signature;
  int          mode = 0;
  int          total = 0, bad = 0;
  logic [15:0] mg;
  logic [7:0]  mm;

  always #5 clk = ~clk;

  always_comb begin
    case (mode)
      0: resp = stim;
      1: resp = ~stim;
      default: resp = cval;
    endcase
  end

  xtalk_bist #(.N(N), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .cycles(cycles),
    .stim(stim), .resp(resp), .done(done), .signature(signature)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] even_bits(input logic [15:0] g);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = g[2*i];
    return r;
  endfunction

  function automatic logic [7:0] model_resp(input logic [7:0] s);
    return mode == 0 ? s : mode == 1 ? ~s : cval;
  endfunction

  // one model step, using the stimulus the current model state presents
  task automatic model_step();
    logic [7:0] r;
    r  = model_resp(even_bits(mg));
    mm = {mm[6:0], ^(mm & MT)} ^ r;
    mg = {mg[14:0], ^(mg & GT)};
  endtask

  // called at a falling edge; leaves at the falling edge after the start edge
  task automatic launch(input logic [23:0] s, input logic [15:0] g);
    seed = s; cycles = g; start = 1;
    @(negedge clk); start = 0;
    mg = s[15:0]; mm = s[23:16];
  endtask

  task automatic run_session(input string rq, input logic [23:0] s, input logic [15:0] g, input int m);
    mode = m;
    launch(s, g);
    for (int k = 0; k < g; k++) begin
      if (k == 0) chk({rq, " done low while running"}, done, 0);
      model_step();
      @(negedge clk);
    end
    chk({rq, " done"}, done, 1);
    chk({rq, " signature"}, signature, {mm, mg});
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 signature", signature, 0);
    chk("R1 stim", stim, 0);
    repeat (3) @(negedge clk);
    chk("R1 no stepping", signature, 0);
  endtask

  task automatic t_zero_g();
    launch(24'h5A_1234, 16'd0);
    chk("R7 g=0 done", done, 1);
    chk("R2 R9 seed loaded", signature, 24'h5A_1234);
  endtask

  task automatic t_stim_map();
    mode = 2; cval = 8'h00;
    launch(24'h00_AAAA, 16'd40);
    chk("R3 stim even stages", stim, even_bits(16'hAAAA));
    for (int k = 0; k < 5; k++) begin
      model_step();
      @(negedge clk);
      chk("R3 R4 stim per step", stim, even_bits(mg));
    end
    for (int k = 5; k < 40; k++) @(negedge clk);
  endtask

  task automatic t_patterns();
    run_session("R4 R6 loopback", 24'h3C_BEEF, 16'd37, 0);
    run_session("R6 inverted", 24'hC3_0F01, 16'd50, 1);
    cval = 8'hA5;
    run_session("R6 constant", 24'h00_8001, 16'd1, 2);
  endtask

  task automatic t_hold();
    logic [23:0] snap;
    snap = signature;
    mode = 2; cval = 8'hFF;
    repeat (12) @(negedge clk);
    chk("R8 signature frozen", signature, snap);
    chk("R8 done stays", done, 1);
  endtask

  task automatic t_restart();
    mode = 0;
    launch(24'h11_2222, 16'd200);
    repeat (10) @(negedge clk);
    run_session("R2 restart mid-session", 24'h77_0F0F, 16'd3, 0);
  endtask

  task automatic t_zero_lock();
    mode = 2; cval = 8'h3C;
    launch(24'h99_0000, 16'd20);
    for (int k = 0; k < 20; k++) begin
      model_step();
      @(negedge clk);
    end
    chk("R5 zero generator stays zero", signature[15:0], 0);
    chk("R5 zero stim", stim, 0);
    chk("R6 misr with zero gen", signature[23:16], mm);
  endtask

  task automatic t_period();
    int early;
    early = 0;
    mode = 2; cval = 8'h00;
    launch(24'h00_0001, 16'hFFFF);
    for (int k = 1; k < 65535; k++) begin
      @(negedge clk);
      if (signature[15:0] == 16'h0001) early++;
    end
    @(negedge clk);
    chk("R5 no early return", early, 0);
    chk("R5 period 2^16-1", signature[15:0], 16'h0001);
    chk("R7 done after full period", done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_g();
    t_stim_map();
    t_patterns();
    t_hold();
    t_restart();
    t_zero_lock();
    t_period();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule